// File: doc/BRIEF.md
# Burst-Read Sample FIFO with Programmable Almost-Full

This block sits between a fast converter front end and a slower host processor. Each converter sample arrives as a 9-bit word: an 8-bit sample in the low bits and a 1-bit channel tag in the top bit. Samples are written with a one-cycle valid pulse and held in a synchronous first-in first-out store. The host takes them out with single-cycle read strobes. Writer, reader and store all run on one clock.

Software sets an occupancy threshold through a configuration write. When the stored word count reaches that threshold, the almost-full flag goes high. The low-to-high change of that flag raises an interrupt request. The host answers by draining the store with back-to-back read strobes until the empty flag rises. It then waits for the next interrupt before reading again. Writes that arrive while the store is full, and reads issued while it is empty, are handled safely and recorded in sticky error flags.

Top module: `sample_burst_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `empty` is 1 and `almost_full`, `irq`, `overflow`, `underflow` and `rd_word` are all 0. The threshold register resets to 0.
- R2: Words leave the store in the order they were accepted, with every bit preserved. A read strobe given while the store holds at least one word presents the oldest word on `rd_word` on the cycle after the strobe.
- R3: `empty` is 1 exactly when no words are stored. When one cycle carries both an accepted write and a read of a non-empty store, the occupancy is unchanged.
- R4: `almost_full` is 1 while the occupancy is at or above the effective threshold. The effective threshold equals the value last loaded through `thr_we`/`thr_value`. A loaded value of 0, or any value above the depth, means the full depth (256 by default).
- R5: `irq` goes to 1 one cycle after `almost_full` goes from 0 to 1, whether the rise comes from a write or from a threshold change. It then stays at 1 until a read strobe, and is 0 on the cycle after that strobe. If a rise and a read strobe fall in the same cycle, the rise wins.
- R6: A write while the store holds the full depth is dropped, even if a read strobe comes in the same cycle. The dropped write sets `overflow`, which stays at 1 until reset.
- R7: A read strobe while the store is empty leaves `rd_word` at its previous value and sets `underflow`, which stays at 1 until reset. A write in that same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request for `wr_word` this cycle |
| wr_word | input | 9 | Sample word: bit 8 channel tag, bits 7:0 sample |
| rd_strobe | input | 1 | Host read request, one word per cycle |
| rd_word | output | 9 | Registered read data, valid the cycle after the strobe |
| thr_we | input | 1 | Load `thr_value` into the threshold register |
| thr_value | input | 9 | New almost-full threshold in words (0 means full depth) |
| almost_full | output | 1 | Occupancy at or above the effective threshold |
| empty | output | 1 | No words stored |
| overflow | output | 1 | Sticky: a write was dropped because the store was full |
| underflow | output | 1 | Sticky: a read was issued while the store was empty |
| irq | output | 1 | Interrupt request to the host, cleared by a read strobe |

## Verification
The assertions assume the inputs never go unknown after reset. They also assume that a threshold load, a write and a read may each arrive in any cycle, with no protocol ordering between them; the properties are written so that every combination is legal. The stimulus changes inputs only on the falling clock edge, holds each request for exactly one cycle, and covers each combination on purpose: reads on an empty store, writes on a full store, simultaneous reads and writes, and threshold loads while words are stored. Every cycle the bench compares `empty`, `almost_full`, `irq` and the read data against a word-queue model of the requirements.

// File: rtl/sbf_pkg.sv
// Package: shared types and helpers for the burst-read sample FIFO.
// Assumes: thresholds and depths fit in 32 bits.
package sbf_pkg;

    // Encoding of the accepted operations in one cycle: {pop, push}.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } sbf_op_e;

    // Map a programmed threshold onto the level actually compared.
    function automatic int unsigned sbf_limit(input int unsigned thr, input int unsigned depth);
        return ((thr == 0) || (thr > depth)) ? depth : thr;
    endfunction

endpackage

// File: rtl/sbf_store.sv
// Module: word storage with a registered read port.
// Assumes: the controller never asserts wr_en when full or rd_en when empty,
// and addresses stay below DEPTH.
module sbf_store #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned WORD_W = 9,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Register the oldest word on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/sbf_ctrl.sv
// Module: pointer, occupancy and error-flag control.
// Assumes: DEPTH >= 2. A write when full is dropped even with a read in the
// same cycle. A read when empty is not accepted.
module sbf_ctrl #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_strobe,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          overflow,
    output logic          underflow
);
    import sbf_pkg::*;

    logic          is_full;
    logic [AW-1:0] wptr_nx;
    logic [AW-1:0] rptr_nx;
    sbf_op_e       op;

    // Decode acceptance of this cycle's requests from the stored count.
    always_comb begin
        is_full = (count == CW'(DEPTH));
        empty   = (count == '0);
        wr_en   = wr_valid && !is_full;
        rd_en   = rd_strobe && !empty;
        op      = sbf_op_e'({rd_en, wr_en});
    end

    // Pointer advance: natural wrap for a power-of-two depth, compare otherwise.
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
        assign wptr_nx = wptr + AW'(1);
        assign rptr_nx = rptr + AW'(1);
    end else begin : g_wrap
        assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
        assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end

    // Move the pointers and the occupancy count by the accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= wptr_nx;
            if (rd_en) rptr <= rptr_nx;
            case (op)
                OP_PUSH: count <= count + CW'(1);
                OP_POP:  count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (wr_valid && is_full) overflow  <= 1'b1;
            if (rd_strobe && empty)  underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/sbf_irq.sv
// Module: threshold register, almost-full compare and interrupt request.
// Assumes: count never exceeds DEPTH. On the same cycle, a rising almost-full
// takes priority over the clearing read strobe.
module sbf_irq #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_we,
    input  logic [CW-1:0] thr_value,
    input  logic [CW-1:0] count,
    input  logic          rd_strobe,
    output logic          almost_full,
    output logic          irq
);
    import sbf_pkg::*;

    logic [CW-1:0] thr_q;
    logic [CW-1:0] limit;
    logic          af_prev;

    // Hold the software-programmed threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_value;
        end
    end

    // Compare the occupancy against the effective threshold.
    always_comb begin
        limit       = CW'(sbf_limit(32'(thr_q), DEPTH));
        almost_full = (count >= limit);
    end

    // Track the previous flag value and raise or drop the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_prev <= 1'b0;
            irq     <= 1'b0;
        end else begin
            af_prev <= almost_full;
            if (almost_full && !af_prev) begin
                irq <= 1'b1;
            end else if (rd_strobe) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sample_burst_fifo.sv
// Module: top of the burst-read sample FIFO.
// Assumes: a single clock domain. The host drains in bursts started by irq.
// Word layout is {tag, sample} and is carried through unchanged.
module sample_burst_fifo #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TAG_W  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [DATA_W+TAG_W-1:0]    wr_word,
    input  logic                       rd_strobe,
    output logic [DATA_W+TAG_W-1:0]    rd_word,
    input  logic                       thr_we,
    input  logic [$clog2(DEPTH+1)-1:0] thr_value,
    output logic                       almost_full,
    output logic                       empty,
    output logic                       overflow,
    output logic                       underflow,
    output logic                       irq
);
    localparam int unsigned WORD_W = DATA_W + TAG_W;
    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned CW     = $clog2(DEPTH + 1);

    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] occ;

    sbf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .rd_strobe (rd_strobe),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wptr      (wptr),
        .rptr      (rptr),
        .count     (occ),
        .empty     (empty),
        .overflow  (overflow),
        .underflow (underflow)
    );

    sbf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wptr),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_addr (rptr),
        .rd_word (rd_word)
    );

    sbf_irq #(.DEPTH(DEPTH), .CW(CW)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_we      (thr_we),
        .thr_value   (thr_value),
        .count       (occ),
        .rd_strobe   (rd_strobe),
        .almost_full (almost_full),
        .irq         (irq)
    );

endmodule

// File: rtl/sbf_checker.sv
// Module: property checker for the burst-read sample FIFO, bound to the top.
// Assumes: inputs are known after reset; any mix of requests is legal.
module sbf_checker #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned WORD_W = 9,
    parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              rd_strobe,
    input logic [WORD_W-1:0] rd_word,
    input logic              almost_full,
    input logic              empty,
    input logic              overflow,
    input logic              underflow,
    input logic              irq,
    input logic [CW-1:0]     occ
);

    // R3: the occupancy never goes past the depth.
    always @(posedge clk) begin
        if (rst_n) begin
            assert_occ_bound_R3: assert (occ <= CW'(DEPTH));
        end
    end

    assert_hold_on_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && rd_strobe && wr_valid && occ != CW'(DEPTH)) |=> $stable(occ));

    assert_af_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        almost_full |-> !empty);

    assert_irq_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(almost_full) |=> irq);

    assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_strobe && !$rose(almost_full)) |=> !irq);

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_strobe) |=> irq);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && wr_valid) |=> overflow);

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && wr_valid && rd_strobe) |=> (occ == CW'(DEPTH - 1)));

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_strobe) |=> (underflow && $stable(rd_word)));

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

endmodule

bind sample_burst_fifo sbf_checker #(
    .DEPTH  (DEPTH),
    .WORD_W (DATA_W + TAG_W),
    .CW     ($clog2(DEPTH + 1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .rd_strobe   (rd_strobe),
    .rd_word     (rd_word),
    .almost_full (almost_full),
    .empty       (empty),
    .overflow    (overflow),
    .underflow   (underflow),
    .irq         (irq),
    .occ         (occ)
);

// File: tb/sim_sample_burst_fifo.sv
module sim_sample_burst_fifo;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_word = '0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rd_word;
    logic       thr_we = 1'b0;
    logic [8:0] thr_value = '0;
    logic       almost_full, empty, overflow, underflow, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference model state
    logic [8:0] model [$];
    logic [8:0] last_rd = '0;
    int  eff     = DEPTH;
    bit  af_last = 0;
    bit  irq_m   = 0;

    always #2 clk = ~clk;

    sample_burst_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .rd_strobe(rd_strobe), .rd_word(rd_word), .thr_we(thr_we),
        .thr_value(thr_value), .almost_full(almost_full), .empty(empty),
        .overflow(overflow), .underflow(underflow), .irq(irq)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Advance the interrupt model by one clock edge (pre-edge state).
    task automatic irq_model(input bit rs);
        bit af_now;
        af_now = (model.size() >= eff);
        if (af_now && !af_last) irq_m = 1;
        else if (rs) irq_m = 0;
        af_last = af_now;
    endtask

    task automatic flags_check();
        check("R3 empty flag", empty, model.size() == 0);
        check("R4 almost_full flag", almost_full, model.size() >= eff);
        check("R5 irq", irq, irq_m);
    endtask

    // One cycle with optional write and read; checks the result afterwards.
    task automatic step(input bit wv, input logic [8:0] wd, input bit rs);
        int sz;
        bit popped;
        logic [8:0] exp_rd;
        sz = model.size();
        popped = 0;
        exp_rd = last_rd;
        wr_valid = wv; wr_word = wd; rd_strobe = rs;
        irq_model(rs);
        if (rs && sz != 0) begin exp_rd = model.pop_front(); popped = 1; end
        if (wv && sz != DEPTH) model.push_back(wd);
        @(negedge clk);
        wr_valid = 0; rd_strobe = 0;
        if (rs) begin
            if (popped) check("R2 read order/data", rd_word, exp_rd);
            else        check("R7 rd_word held on empty read", rd_word, exp_rd);
        end
        last_rd = exp_rd;
        flags_check();
    endtask

    task automatic set_thr(input int v);
        thr_we = 1; thr_value = v[8:0];
        irq_model(0);
        @(negedge clk);
        thr_we = 0;
        eff = (v == 0 || v > DEPTH) ? DEPTH : v;
        flags_check();
    endtask

    task automatic drain();
        while (model.size() != 0) step(0, '0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 empty in reset", empty, 1);
        check("R1 irq in reset", irq, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 empty", empty, 1);
        check("R1 almost_full", almost_full, 0);
        check("R1 irq", irq, 0);
        check("R1 overflow", overflow, 0);
        check("R1 underflow", underflow, 0);
        check("R1 rd_word", rd_word, 0);
    endtask

    task automatic t_burst();
        set_thr(4);
        for (int i = 0; i < 3; i++) step(1, 9'(9'h010 + i + (i[0] << 8)), 0);
        check("R4 below threshold", almost_full, 0);
        step(1, 9'h1A5, 0);
        check("R4 at threshold", almost_full, 1);
        check("R5 irq lags rise", irq, 0);
        step(0, '0, 0);
        check("R5 irq raised", irq, 1);
        step(0, '0, 0);
        check("R5 irq held", irq, 1);
        step(0, '0, 1);
        check("R5 irq cleared by strobe", irq, 0);
        drain();
        check("R3 empty after burst", empty, 1);
    endtask

    task automatic t_simul();
        step(1, 9'h0AA, 0);
        step(1, 9'h155, 0);
        for (int i = 0; i < 4; i++) step(1, 9'(9'h020 + i), 1);
        check("R3 occupancy unchanged", int'(model.size()), 2);
        step(0, '0, 1);
        check("R3 not empty with one left", empty, 0);
        step(0, '0, 1);
        check("R3 empty after two reads", empty, 1);
    endtask

    task automatic t_underflow();
        step(0, '0, 1);
        check("R7 underflow set", underflow, 1);
        step(1, 9'h17E, 1);
        check("R7 write kept on empty read", empty, 0);
        step(0, '0, 1);
        check("R7 stored word readable", rd_word, 9'h17E);
        step(0, '0, 0);
        check("R7 underflow sticky", underflow, 1);
    endtask

    task automatic t_thr_change();
        set_thr(0);
        for (int i = 0; i < 5; i++) step(1, 9'(9'h040 + i), 0);
        check("R4 zero threshold means depth", almost_full, 0);
        set_thr(5);
        check("R4 threshold lowered", almost_full, 1);
        step(0, '0, 0);
        check("R5 irq from threshold change", irq, 1);
        set_thr(300);
        check("R4 threshold above depth", almost_full, 0);
        step(0, '0, 0);
        drain();
    endtask

    task automatic t_full();
        set_thr(0);
        for (int i = 0; i < DEPTH - 1; i++) step(1, 9'(i * 7 + 3), 0);
        check("R4 one below depth", almost_full, 0);
        step(1, 9'h1FF, 0);
        check("R4 full depth", almost_full, 1);
        check("R6 no overflow yet", overflow, 0);
        step(1, 9'h0DD, 0);
        check("R6 overflow on full write", overflow, 1);
        step(1, 9'h0EE, 1);
        check("R6 write dropped with read", almost_full, 0);
        drain();
        check("R6 overflow sticky", overflow, 1);
        check("R3 empty after full drain", empty, 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst();
        t_simul();
        t_underflow();
        t_thr_change();
        t_full();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule